// File: doc/BRIEF.md
# Synchronous Rectifier Gate Sequencer

This block decides, clock by clock, whether the gate of a secondary-side rectifier switch is on. Its inputs are single-bit events that earlier logic has already digitised and synchronised. One says conduction has begun, because the sense voltage dropped below the turn-on level. One says the turn-off threshold was crossed. One says the sense voltage is positive again. The others are a fast trigger line, a supply-good flag and a disable request from a light-load detector. The block models only the order of events and the timers. Comparators, clamp levels and drive strength are outside it.

After turn-on, the turn-off event is blanked for a programmable number of cycles, so that ringing right after switching is rejected. After turn-off, a new turn-on is held back until a programmable off interval has passed and the sense voltage has been seen positive. The trigger line forces the gate off immediately, and holding it high for long puts the block into a low-power disabled state. A pulse-length watchdog caps the on time. An undervoltage report, followed by a start-up delay, keeps the gate off until the supply can be trusted.

All five interval lengths are cycle counts taken from configuration ports. They are captured on every clock edge while reset is asserted.

Top module: `sr_gate_seq`

## Requirements
- R1: While `rstN` is low, the configuration ports are captured at each clock edge. The first rising edge with `rstN` high after reset finds `gateOn`=0, `disabled`=0 and `status`=0 (start-up).
- R2: While `supplyOk` is high, the start-up phase counter advances by one per clock edge. The block leaves start-up for armed (`status`=1) at the edge where that counter, begun at 0, has reached `startDelayCfg`, which is the (`startDelayCfg`+1)-th consecutive edge with `supplyOk` high.
- R3: In the armed state, with `trigIn` and `lightDis` low, `condStart` sampled high turns `gateOn` on at that edge (`status`=2).
- R4: While the gate is on, `offThresh` turns the gate off only once the on-phase counter (0 at the turn-on edge, +1 per edge) has reached `minOnCfg`. Before that, `offThresh` has no effect on `gateOn`.
- R5: After turn-off (`status`=3), `condStart` is ignored. The block re-arms only at an edge where the off-phase counter has reached `minOffCfg` and `senseReset` has been high at some edge of this off phase, the current edge included.
- R6: `trigIn` sampled high turns the gate off at that edge if it is on, and prevents any turn-on at that edge in every state.
- R7: When `trigIn` has been high at more than `trigHoldCfg` consecutive edges, the block enters disabled (`status`=4, `disabled`=1, `gateOn`=0).
- R8: Disabled is left for armed only at an edge where `trigIn` and `lightDis` are low and `condStart` is high. That edge does not turn the gate on.
- R9: `lightDis` sampled high in the armed, on or off state moves the block to disabled at that edge.
- R10: While on, the gate is forced off at the edge where the on-phase counter has reached `maxOnCfg`, whatever `offThresh` does.
- R11: `supplyOk` sampled low forces start-up from any state, with the gate off and the start-up counter restarted.
- R12: Priority at each edge, from highest to lowest: undervoltage, long trigger, leaving disabled, start-up timing, light-load disable, trigger, then the normal turn-on and turn-off rules. `gateOn` and `disabled` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset; also captures the configuration |
| condStart | input | 1 | Sense voltage is below the turn-on level (conduction begun) |
| offThresh | input | 1 | Sense voltage has crossed the turn-off threshold |
| senseReset | input | 1 | Sense voltage is positive again |
| trigIn | input | 1 | Fast turn-off / disable trigger |
| supplyOk | input | 1 | Supply is above the undervoltage level |
| lightDis | input | 1 | Disable request from the light-load detector |
| minOnCfg | input | CNT_W | Turn-off blanking length, in cycles |
| minOffCfg | input | CNT_W | Re-arm blocking length, in cycles |
| maxOnCfg | input | CNT_W | Watchdog limit on the gate pulse, in cycles |
| startDelayCfg | input | CNT_W | Start-up delay after the supply becomes good, in cycles |
| trigHoldCfg | input | CNT_W | Trigger hold length that leads to disabled, in cycles |
| gateOn | output | 1 | Registered gate enable |
| disabled | output | 1 | Registered low-power disabled indication |
| status | output | 3 | State: 0 start-up, 1 armed, 2 on, 3 off, 4 disabled |

## Verification
The hardest case to reach from the ports is the off phase in which the minimum off time has expired but no positive sense event has arrived yet. A conduction-start request at that point must still be refused. The stimulus holds `condStart` high through the whole off phase with `senseReset` low, and only later pulses `senseReset`. Competing force sources meeting on the same edge are another hard case. These are reached by a long randomized phase with weighted trigger, light-load and supply glitches, checked against a behavioural model on every cycle, in addition to directed phases for each timer limit.

// File: rtl/sr_gate_seq_pkg.sv
package sr_gate_seq_pkg;

  typedef enum logic [2:0] {
    ST_STARTUP  = 3'd0,
    ST_ARMED    = 3'd1,
    ST_ON       = 3'd2,
    ST_OFF      = 3'd3,
    ST_DISABLED = 3'd4
  } seqState_t;

  // control -> datapath
  typedef struct packed {
    logic clrPhase;   // restart the phase counter
    logic clrSense;   // forget the positive-sense memory
  } seqStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic startDone;
    logic minOnDone;
    logic minOffDone;
    logic maxOnHit;
    logic trigLong;
    logic senseSeen;
  } seqFlags_t;

endpackage

// File: rtl/sr_gate_seq_dp.sv
module sr_gate_seq_dp
  import sr_gate_seq_pkg::*;
#(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigIn,
  input  logic             senseReset,
  input  logic [CNT_W-1:0] minOnCfg,
  input  logic [CNT_W-1:0] minOffCfg,
  input  logic [CNT_W-1:0] maxOnCfg,
  input  logic [CNT_W-1:0] startDelayCfg,
  input  logic [CNT_W-1:0] trigHoldCfg,
  input  seqStrobe_t       strb,
  output seqFlags_t        flags
);

  localparam logic [CNT_W-1:0] CNT_SAT = {CNT_W{1'b1}};

  logic [CNT_W-1:0] minOnQ, minOffQ, maxOnQ, startDelayQ, trigHoldQ;
  logic [CNT_W-1:0] phCnt;
  logic [CNT_W-1:0] trigCnt;
  logic             posSeenQ;

  // configuration capture while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) begin
      minOnQ      <= minOnCfg;
      minOffQ     <= minOffCfg;
      maxOnQ      <= maxOnCfg;
      startDelayQ <= startDelayCfg;
      trigHoldQ   <= trigHoldCfg;
    end
  end

  // phase counter shared by every timed state, saturating
  always_ff @(posedge clk) begin
    if (!rstN || strb.clrPhase) begin
      phCnt <= '0;
    end else if (phCnt != CNT_SAT) begin
      phCnt <= phCnt + 1'b1;
    end
  end

  // consecutive trigger-high counter, saturating
  always_ff @(posedge clk) begin
    if (!rstN || !trigIn) begin
      trigCnt <= '0;
    end else if (trigCnt != CNT_SAT) begin
      trigCnt <= trigCnt + 1'b1;
    end
  end

  // positive-sense memory for the off phase
  always_ff @(posedge clk) begin
    if (!rstN || strb.clrSense) begin
      posSeenQ <= 1'b0;
    end else if (senseReset) begin
      posSeenQ <= 1'b1;
    end
  end

  always_comb begin
    flags.startDone  = (phCnt >= startDelayQ);
    flags.minOnDone  = (phCnt >= minOnQ);
    flags.minOffDone = (phCnt >= minOffQ);
    flags.maxOnHit   = (phCnt >= maxOnQ);
    flags.trigLong   = trigIn && (trigCnt >= trigHoldQ);
    flags.senseSeen  = posSeenQ || senseReset;
  end

endmodule

// File: rtl/sr_gate_seq_ctrl.sv
module sr_gate_seq_ctrl
  import sr_gate_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       condStart,
  input  logic       offThresh,
  input  logic       trigIn,
  input  logic       supplyOk,
  input  logic       lightDis,
  input  seqFlags_t  flags,
  output seqStrobe_t strb,
  output logic       gateOn,
  output logic       disabled,
  output logic [2:0] status
);

  seqState_t stQ, stD;

  always_comb begin
    stD = stQ;
    if (!supplyOk) begin
      stD = ST_STARTUP;
    end else if (flags.trigLong) begin
      stD = ST_DISABLED;
    end else if (stQ == ST_DISABLED) begin
      if (!trigIn && !lightDis && condStart) stD = ST_ARMED;
    end else if (stQ == ST_STARTUP) begin
      if (flags.startDone) stD = ST_ARMED;
    end else if (lightDis) begin
      stD = ST_DISABLED;
    end else if (trigIn) begin
      if (stQ == ST_ON) stD = ST_OFF;
    end else begin
      case (stQ)
        ST_ARMED: if (condStart) stD = ST_ON;
        ST_ON:    if (flags.maxOnHit || (offThresh && flags.minOnDone)) stD = ST_OFF;
        ST_OFF:   if (flags.minOffDone && flags.senseSeen) stD = ST_ARMED;
        default:  stD = stQ;
      endcase
    end
  end

  always_comb begin
    strb.clrPhase = (stD != stQ) || !supplyOk;
    strb.clrSense = (stD != stQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ      <= ST_STARTUP;
      gateOn   <= 1'b0;
      disabled <= 1'b0;
    end else begin
      stQ      <= stD;
      gateOn   <= (stD == ST_ON);
      disabled <= (stD == ST_DISABLED);
    end
  end

  assign status = stQ;

  // R6: a trigger never lets the gate be on after the edge that saw it
  a_r6_trig_forces_off: assert property (@(posedge clk) disable iff (!rstN)
    trigIn |=> !gateOn);

  // R11: undervoltage returns to start-up with the gate off
  a_r11_uv_holds_off: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> (!gateOn && status == 3'd0));

  // R5: a turn-off is never followed directly by a new turn-on
  a_r5_no_retrigger: assert property (@(posedge clk) disable iff (!rstN)
    $fell(gateOn) |=> !gateOn);

  // R10: watchdog limit reached while on ends the pulse
  a_r10_watchdog: assert property (@(posedge clk) disable iff (!rstN)
    (gateOn && flags.maxOnHit) |=> !gateOn);

  // R12: gate and disabled indication are exclusive
  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({gateOn, disabled}));

  // R7: a long trigger lands in the disabled state
  a_r7_long_trig: assert property (@(posedge clk) disable iff (!rstN)
    (supplyOk && flags.trigLong) |=> disabled);

endmodule

// File: rtl/sr_gate_seq.sv
module sr_gate_seq
  import sr_gate_seq_pkg::*;
#(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             condStart,
  input  logic             offThresh,
  input  logic             senseReset,
  input  logic             trigIn,
  input  logic             supplyOk,
  input  logic             lightDis,
  input  logic [CNT_W-1:0] minOnCfg,
  input  logic [CNT_W-1:0] minOffCfg,
  input  logic [CNT_W-1:0] maxOnCfg,
  input  logic [CNT_W-1:0] startDelayCfg,
  input  logic [CNT_W-1:0] trigHoldCfg,
  output logic             gateOn,
  output logic             disabled,
  output logic [2:0]       status
);

  seqStrobe_t strb;
  seqFlags_t  flags;

  sr_gate_seq_dp #(.CNT_W(CNT_W)) i_dp (
    .clk           (clk),
    .rstN          (rstN),
    .trigIn        (trigIn),
    .senseReset    (senseReset),
    .minOnCfg      (minOnCfg),
    .minOffCfg     (minOffCfg),
    .maxOnCfg      (maxOnCfg),
    .startDelayCfg (startDelayCfg),
    .trigHoldCfg   (trigHoldCfg),
    .strb          (strb),
    .flags         (flags)
  );

  sr_gate_seq_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .condStart (condStart),
    .offThresh (offThresh),
    .trigIn    (trigIn),
    .supplyOk  (supplyOk),
    .lightDis  (lightDis),
    .flags     (flags),
    .strb      (strb),
    .gateOn    (gateOn),
    .disabled  (disabled),
    .status    (status)
  );

endmodule

// File: tb/test_sr_gate_seq.sv
module test_sr_gate_seq;

  localparam int CW = 18;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic condStart = 0, offThresh = 0, senseReset = 0, trigIn = 0, supplyOk = 0, lightDis = 0;
  logic [CW-1:0] minOnCfg = 5, minOffCfg = 4, maxOnCfg = 40, startDelayCfg = 10, trigHoldCfg = 8;
  logic gateOn, disabled;
  logic [2:0] status;

  int checks = 0, errors = 0, cycles = 0;
  string tag = "R1";
  bit done = 0;

  // behavioural reference
  int mSt = 0, mCnt = 0, mTc = 0;
  bit mPos = 0;
  int cMinOn, cMinOff, cMaxOn, cStart, cHold;
  localparam int SAT = (1 << CW) - 1;

  always #10 clk = ~clk;

  sr_gate_seq #(.CNT_W(CW)) i_sr_gate_seq (
    .clk(clk), .rstN(rstN), .condStart(condStart), .offThresh(offThresh),
    .senseReset(senseReset), .trigIn(trigIn), .supplyOk(supplyOk), .lightDis(lightDis),
    .minOnCfg(minOnCfg), .minOffCfg(minOffCfg), .maxOnCfg(maxOnCfg),
    .startDelayCfg(startDelayCfg), .trigHoldCfg(trigHoldCfg),
    .gateOn(gateOn), .disabled(disabled), .status(status)
  );

  always @(posedge clk) begin
    int ns;
    bit clr;
    if (!rstN) begin
      cMinOn = int'(minOnCfg); cMinOff = int'(minOffCfg); cMaxOn = int'(maxOnCfg);
      cStart = int'(startDelayCfg); cHold = int'(trigHoldCfg);
      mSt = 0; mCnt = 0; mTc = 0; mPos = 0;
    end else begin
      ns = mSt;
      if (!supplyOk) ns = 0;
      else if (trigIn && mTc >= cHold) ns = 4;
      else if (mSt == 4) begin
        if (!trigIn && !lightDis && condStart) ns = 1;
      end else if (mSt == 0) begin
        if (mCnt >= cStart) ns = 1;
      end else if (lightDis) ns = 4;
      else if (trigIn) begin
        if (mSt == 2) ns = 3;
      end else if (mSt == 1) begin
        if (condStart) ns = 2;
      end else if (mSt == 2) begin
        if (mCnt >= cMaxOn || (offThresh && mCnt >= cMinOn)) ns = 3;
      end else if (mSt == 3) begin
        if (mCnt >= cMinOff && (mPos || senseReset)) ns = 1;
      end
      clr  = (ns != mSt) || !supplyOk;
      mPos = (ns != mSt) ? 1'b0 : (mPos | senseReset);
      mCnt = clr ? 0 : ((mCnt < SAT) ? mCnt + 1 : mCnt);
      mTc  = trigIn ? ((mTc < SAT) ? mTc + 1 : mTc) : 0;
      mSt  = ns;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    bit eg, ed;
    if (rstN && !done) begin
      eg = (mSt == 2);
      ed = (mSt == 4);
      checks++;
      if (gateOn !== eg || disabled !== ed || status !== 3'(mSt)) begin
        errors++;
        $display("FAIL %s: gate/dis/status actual %b/%b/%0d expected %b/%b/%0d",
                 tag, gateOn, disabled, status, eg, ed, mSt);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1; cyc(1); s = 0;
  endtask

  initial begin
    cyc(3);
    rstN = 1;
    tag = "R1"; cyc(2);
    tag = "R11"; cyc(3); supplyOk = 1; cyc(4); supplyOk = 0; cyc(2); supplyOk = 1;
    tag = "R2"; cyc(14);
    // turn-on, then turn-off threshold held from the start of the pulse
    tag = "R3"; condStart = 1; cyc(1); condStart = 0;
    tag = "R4"; offThresh = 1; cyc(8); offThresh = 0;
    // off phase: min off elapsed, no positive sense yet, conduction requested
    tag = "R5"; condStart = 1; cyc(12); pulse(senseReset); cyc(3); condStart = 0; cyc(2);
    tag = "R10"; cyc(50); pulse(senseReset); cyc(6);
    tag = "R6"; pulse(condStart); cyc(2); pulse(trigIn); cyc(2);
    trigIn = 1; condStart = 1; cyc(2); trigIn = 0; condStart = 0;
    cyc(6); pulse(senseReset); cyc(6);
    tag = "R7"; pulse(condStart); trigIn = 1; cyc(12);
    tag = "R8"; pulse(condStart); trigIn = 0; lightDis = 1; pulse(condStart); lightDis = 0;
    cyc(2); pulse(condStart); cyc(2); pulse(condStart); cyc(3);
    tag = "R9"; lightDis = 1; cyc(1); lightDis = 0; cyc(3); pulse(condStart); cyc(2);
    pulse(condStart); cyc(2);
    tag = "R11"; supplyOk = 0; cyc(2); supplyOk = 1; cyc(13);
    tag = "R12";
    for (int k = 0; k < 6000; k++) begin
      condStart  = ($urandom_range(0, 3) == 0);
      offThresh  = ($urandom_range(0, 2) == 0);
      senseReset = ($urandom_range(0, 4) == 0);
      lightDis   = ($urandom_range(0, 60) == 0);
      supplyOk   = ($urandom_range(0, 150) != 0);
      if ($urandom_range(0, 40) == 0) trigIn = ~trigIn;
      else if (trigIn && $urandom_range(0, 12) == 0) trigIn = 0;
      cyc(1);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule